// File: doc/BRIEF.md
# Claimable Inter-Core Mailbox Slot

This block is one mailbox of an inter-processor messaging unit. A core takes the slot by writing its one-hot channel code into the owner register. It then picks the recipient channels, chooses which channels may interrupt, stores up to seven 32-bit message words, and raises the send bit. Each channel has two interrupt lines: a raw one and a masked one. Recipients see the message interrupt. The owner sees the acknowledge interrupt once a recipient, or the hardware, moves the send register into its acknowledge state.

The owner register acts as a hardware lock. While the slot is taken, no other core can overwrite it. Writing zero frees the slot and wipes every other register in it. In auto-acknowledge mode, the slot turns the message into an acknowledge by itself once the last recipient has removed its bit from the recipient set.

In link mode, the acknowledge interrupt toward the owner is held back. A one-cycle event is produced instead, so that neighbouring logic can start a following slot through that slot's link-send input.

Top module: `ipc_mailbox_slot`

## Requirements
- R1: After reset, every register reads zero and both interrupt vectors are zero. The read port returns the register selected by `rd_addr` one clock later. The map is: owner 0, recipient set/clear/read 1/2/3, mask set/clear/read 4/5/6, send 7, mode 8, data words at 9 and up. Set and clear addresses read back the register they modify.
- R2: A write to the owner register while it is zero loads the written value. While it is nonzero, any nonzero write is ignored.
- R3: A write of all-zeros to the owner register clears the owner, recipient, mask, send, mode and all data words.
- R4: While the owner register is zero, writes to recipient, mask, send, mode and data addresses change nothing.
- R5: A write to a set address ORs the value into the recipient or mask register. A write to a clear address removes the written bits.
- R6: Send encoding: 2'b01 means message and 2'b10 means acknowledge. A write of 2'b11 is discarded and the old value is kept. A single write of 2'b10 moves from message to acknowledge.
- R7: For each channel c, the raw interrupt is (send[0] & recipient[c]) | (send[1] & owner[c]).
- R8: The masked interrupt is the raw interrupt ANDed with the mask register.
- R9: Mode bit 0 enables auto-acknowledge. When it is set, send is 2'b01 and the recipient register is zero, send becomes 2'b10 on the next clock. The data words are left unchanged.
- R10: Mode bit 1 enables linking. It removes the send[1] term from the raw interrupt. `ack_evt_o` is high for exactly the first cycle in which send[1] reads 1 while linking is enabled.
- R11: A pulse on `link_send_i` loads send with 2'b01 when the owner register is nonzero. Otherwise it is ignored.
- R12: Data words can be written and read while the slot is owned. Data addresses at or beyond 9 plus the word count read zero and are not writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 32 | Write value |
| rd_addr | input | 4 | Read address |
| rd_data | output | 32 | Registered read value |
| link_send_i | input | 1 | Start message from a linked neighbour |
| irq_raw_o | output | NUM_CH | Unmasked interrupt per channel |
| irq_masked_o | output | NUM_CH | Masked interrupt per channel |
| ack_evt_o | output | 1 | One-cycle acknowledge event when linking |

## Verification
A stuck or wrongly updated owner register shows up in two places. It breaks the claim read-back one cycle after the write. It also sends the acknowledge interrupt to the wrong channel as soon as send[1] rises. A wrong recipient or send state is visible on `irq_raw_o` in the same cycle it is held. A missed or late auto-acknowledge shows up because the owner's raw bit fails to rise exactly one clock after the recipient set drains. Incomplete wiping on release is exposed by reading each register back in the cycles right after the zero write.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int ADDR_W    = 4;
  localparam int DATA_W    = 32;
  localparam int MAX_WORDS = 7;

  localparam logic [ADDR_W-1:0] A_OWNER   = 4'd0;
  localparam logic [ADDR_W-1:0] A_RCP_SET = 4'd1;
  localparam logic [ADDR_W-1:0] A_RCP_CLR = 4'd2;
  localparam logic [ADDR_W-1:0] A_RCP     = 4'd3;
  localparam logic [ADDR_W-1:0] A_MSK_SET = 4'd4;
  localparam logic [ADDR_W-1:0] A_MSK_CLR = 4'd5;
  localparam logic [ADDR_W-1:0] A_MSK     = 4'd6;
  localparam logic [ADDR_W-1:0] A_SEND    = 4'd7;
  localparam logic [ADDR_W-1:0] A_MODE    = 4'd8;
  localparam logic [ADDR_W-1:0] A_WORD0   = 4'd9;

  localparam logic [1:0] SEND_IDLE = 2'b00;
  localparam logic [1:0] SEND_MSG  = 2'b01;
  localparam logic [1:0] SEND_ACK  = 2'b10;
  localparam logic [1:0] SEND_BAD  = 2'b11;

  // mode bit positions
  localparam int MODE_AUTOACK = 0;
  localparam int MODE_LINK    = 1;
endpackage

// File: rtl/mbx_owner_lock.sv
module mbx_owner_lock #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_owner,
  input  logic              wr_zero,
  input  logic [NUM_CH-1:0] wr_val,
  output logic [NUM_CH-1:0] owner_q,
  output logic              owned,
  output logic              wipe
);
  logic [NUM_CH-1:0] owner_d;

  assign wipe  = wr_owner & wr_zero;
  assign owned = |owner_q;

  always_comb begin
    owner_d = owner_q;
    if (wipe) begin
      owner_d = '0;
    end else if (wr_owner && !owned) begin
      owner_d = wr_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= '0;
    end else begin
      owner_q <= owner_d;
    end
  end
endmodule

// File: rtl/mbx_setclr_reg.sv
module mbx_setclr_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wipe,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  logic [W-1:0] val,
  output logic [W-1:0] q
);
  logic [W-1:0] d;

  always_comb begin
    d = q;
    if (wipe) begin
      d = '0;
    end else if (set_stb) begin
      d = q | val;
    end else if (clr_stb) begin
      d = q & ~val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q <= d;
    end
  end
endmodule

// File: rtl/mbx_send_ctrl.sv
module mbx_send_ctrl
  import mbx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wipe,
  input  logic       owned,
  input  logic       wr_send,
  input  logic       wr_mode,
  input  logic [1:0] wval,
  input  logic       link_send,
  input  logic       rcp_empty,
  output logic [1:0] send_q,
  output logic [1:0] mode_q,
  output logic       ack_evt
);
  logic [1:0] send_d;
  logic [1:0] mode_d;
  logic       ack_d;
  logic       auto_fire;

  assign auto_fire = mode_q[MODE_AUTOACK] && (send_q == SEND_MSG) && rcp_empty;

  always_comb begin
    send_d = send_q;
    if (wipe) begin
      send_d = SEND_IDLE;
    end else if (owned) begin
      if (wr_send && (wval != SEND_BAD)) begin
        send_d = wval;
      end else if (link_send) begin
        send_d = SEND_MSG;
      end else if (auto_fire) begin
        send_d = SEND_ACK;
      end
    end
  end

  always_comb begin
    mode_d = mode_q;
    if (wipe) begin
      mode_d = '0;
    end else if (owned && wr_mode) begin
      mode_d = wval;
    end
  end

  assign ack_d = send_d[1] & ~send_q[1] & mode_q[MODE_LINK];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      send_q  <= '0;
      mode_q  <= '0;
      ack_evt <= 1'b0;
    end else begin
      send_q  <= send_d;
      mode_q  <= mode_d;
      ack_evt <= ack_d;
    end
  end
endmodule

// File: rtl/mbx_data_bank.sv
module mbx_data_bank
  import mbx_pkg::*;
#(
  parameter int NUM_WORDS = 4,
  localparam int BANK = (NUM_WORDS > 0) ? NUM_WORDS : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wipe,
  input  logic                       wr_ok,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [BANK-1:0][DATA_W-1:0] words
);
  generate
    if (NUM_WORDS == 0) begin : g_none
      assign words = '0;
    end else begin : g_bank
      for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        logic              hit;
        logic [DATA_W-1:0] w_d;
        logic [DATA_W-1:0] w_q;

        assign hit = wr_ok && (wr_addr == ADDR_W'(int'(A_WORD0) + i));

        always_comb begin
          w_d = w_q;
          if (wipe) begin
            w_d = '0;
          end else if (hit) begin
            w_d = wr_data;
          end
        end

        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            w_q <= '0;
          end else begin
            w_q <= w_d;
          end
        end

        assign words[i] = w_q;
      end
    end
  endgenerate
endmodule

// File: rtl/ipc_mailbox_slot.sv
module ipc_mailbox_slot
  import mbx_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int NUM_WORDS = 4,
  localparam int BANK = (NUM_WORDS > 0) ? NUM_WORDS : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [3:0]        rd_addr,
  output logic [31:0]       rd_data,
  input  logic              link_send_i,
  output logic [NUM_CH-1:0] irq_raw_o,
  output logic [NUM_CH-1:0] irq_masked_o,
  output logic              ack_evt_o
);
  logic [NUM_CH-1:0] owner_q;
  logic [NUM_CH-1:0] rcp_q;
  logic [NUM_CH-1:0] msk_q;
  logic [1:0]        send_q;
  logic [1:0]        mode_q;
  logic              owned;
  logic              wipe;
  logic              wr_ok;
  logic [BANK-1:0][DATA_W-1:0] words;
  logic [DATA_W-1:0] rd_d;
  logic [DATA_W-1:0] rd_q;
  logic              ack_term;

  assign wr_ok = wr_en & owned;

  mbx_owner_lock #(.NUM_CH(NUM_CH)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_owner (wr_en && (wr_addr == A_OWNER)),
    .wr_zero  (wr_data == '0),
    .wr_val   (wr_data[NUM_CH-1:0]),
    .owner_q  (owner_q),
    .owned    (owned),
    .wipe     (wipe)
  );

  mbx_setclr_reg #(.W(NUM_CH)) u_rcp (
    .clk     (clk),
    .rst_n   (rst_n),
    .wipe    (wipe),
    .set_stb (wr_ok && (wr_addr == A_RCP_SET)),
    .clr_stb (wr_ok && (wr_addr == A_RCP_CLR)),
    .val     (wr_data[NUM_CH-1:0]),
    .q       (rcp_q)
  );

  mbx_setclr_reg #(.W(NUM_CH)) u_msk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wipe    (wipe),
    .set_stb (wr_ok && (wr_addr == A_MSK_SET)),
    .clr_stb (wr_ok && (wr_addr == A_MSK_CLR)),
    .val     (wr_data[NUM_CH-1:0]),
    .q       (msk_q)
  );

  mbx_send_ctrl u_send (
    .clk       (clk),
    .rst_n     (rst_n),
    .wipe      (wipe),
    .owned     (owned),
    .wr_send   (wr_en && (wr_addr == A_SEND)),
    .wr_mode   (wr_en && (wr_addr == A_MODE)),
    .wval      (wr_data[1:0]),
    .link_send (link_send_i),
    .rcp_empty (rcp_q == '0),
    .send_q    (send_q),
    .mode_q    (mode_q),
    .ack_evt   (ack_evt_o)
  );

  mbx_data_bank #(.NUM_WORDS(NUM_WORDS)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wipe    (wipe),
    .wr_ok   (wr_ok),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .words   (words)
  );

  // acknowledge toward the owner is withheld while linking
  assign ack_term     = send_q[1] & ~mode_q[MODE_LINK];
  assign irq_raw_o    = ({NUM_CH{send_q[0]}} & rcp_q) | ({NUM_CH{ack_term}} & owner_q);
  assign irq_masked_o = irq_raw_o & msk_q;

  always_comb begin
    rd_d = '0;
    case (rd_addr)
      A_OWNER:                       rd_d = DATA_W'(owner_q);
      A_RCP_SET, A_RCP_CLR, A_RCP:   rd_d = DATA_W'(rcp_q);
      A_MSK_SET, A_MSK_CLR, A_MSK:   rd_d = DATA_W'(msk_q);
      A_SEND:                        rd_d = DATA_W'(send_q);
      A_MODE:                        rd_d = DATA_W'(mode_q);
      default: begin
        for (int i = 0; i < NUM_WORDS; i++) begin
          if (rd_addr == ADDR_W'(int'(A_WORD0) + i)) begin
            rd_d = words[i];
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else begin
      rd_q <= rd_d;
    end
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/mbx_slot_chk.sv
module mbx_slot_chk
  import mbx_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [3:0]        wr_addr,
  input logic [31:0]       wr_data,
  input logic              link_send_i,
  input logic [NUM_CH-1:0] owner_q,
  input logic [NUM_CH-1:0] rcp_q,
  input logic [NUM_CH-1:0] msk_q,
  input logic [1:0]        send_q,
  input logic [1:0]        mode_q,
  input logic [NUM_CH-1:0] irq_raw_o
);
  logic rel_wr;
  assign rel_wr = wr_en && (wr_addr == A_OWNER) && (wr_data == '0);

  AST_SEND_NEVER_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    send_q != SEND_BAD); // R6

  AST_OWNER_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q != '0 && !rel_wr) |=> $stable(owner_q)); // R2

  AST_RELEASE_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
    rel_wr |=> (owner_q == '0 && rcp_q == '0 && msk_q == '0 && send_q == '0 && mode_q == '0)); // R3

  AST_FREE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == '0) |-> (irq_raw_o == '0 && rcp_q == '0 && msk_q == '0)); // R4

  AST_AUTO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[MODE_AUTOACK] && send_q == SEND_MSG && rcp_q == '0 && owner_q != '0
     && !wr_en && !link_send_i) |=> (send_q == SEND_ACK)); // R9

  AST_LINK_START: assert property (@(posedge clk) disable iff (!rst_n)
    (link_send_i && owner_q != '0 && !wr_en) |=> (send_q == SEND_MSG)); // R11
endmodule

bind ipc_mailbox_slot mbx_slot_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .link_send_i (link_send_i),
  .owner_q     (owner_q),
  .rcp_q       (rcp_q),
  .msk_q       (msk_q),
  .send_q      (send_q),
  .mode_q      (mode_q),
  .irq_raw_o   (irq_raw_o)
);

// File: tb/tb_ipc_mailbox_slot.sv
`timescale 1ns/1ps
module tb_ipc_mailbox_slot;
  import mbx_pkg::*;

  localparam int NCH = 8;
  localparam int NW  = 4;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           wr_en;
  logic [3:0]     wr_addr;
  logic [31:0]    wr_data;
  logic [3:0]     rd_addr;
  logic [31:0]    rd_data;
  logic           link_send_i;
  logic [NCH-1:0] irq_raw_o;
  logic [NCH-1:0] irq_masked_o;
  logic           ack_evt_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_req = 1'b0;
  logic        req_seen = 1'b0;

  always #2.5 clk = ~clk;

  ipc_mailbox_slot #(.NUM_CH(NCH), .NUM_WORDS(NW)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .rd_addr      (rd_addr),
    .rd_data      (rd_data),
    .link_send_i  (link_send_i),
    .irq_raw_o    (irq_raw_o),
    .irq_masked_o (irq_masked_o),
    .ack_evt_o    (ack_evt_o)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: read data appears one clock after the request
  always @(posedge clk) req_seen <= rd_req;

  always @(negedge clk) begin
    if (req_seen) begin
      if (exp_q.size() == 0) begin
        chk(rd_data, 32'hDEAD_BEEF, "scoreboard underflow");
      end else begin
        chk(rd_data, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    rd_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr = '0; link_send_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk(32'(irq_raw_o), 0, "R1 raw irq after reset");
    chk(32'(irq_masked_o), 0, "R1 masked irq after reset");
    rd(A_OWNER, 0, "R1 owner after reset");
    rd(A_SEND, 0, "R1 send after reset");

    // R4 writes while free
    wr(A_RCP_SET, 32'hFF);
    wr(A_MODE, 32'h3);
    wr(A_SEND, 32'h1);
    wr(A_WORD0, 32'h1234_5678);
    rd(A_RCP, 0, "R4 recipient unchanged while free");
    rd(A_MODE, 0, "R4 mode unchanged while free");
    rd(A_SEND, 0, "R4 send unchanged while free");
    rd(A_WORD0, 0, "R4 data unchanged while free");
    chk(32'(irq_raw_o), 0, "R4 no irq while free");

    // R2 claim and lock
    wr(A_OWNER, 32'h01);
    rd(A_OWNER, 32'h01, "R2 claim loads owner");
    wr(A_OWNER, 32'h04);
    rd(A_OWNER, 32'h01, "R2 second claim ignored");

    // R5 set/clear
    wr(A_RCP_SET, 32'h06);
    wr(A_RCP_CLR, 32'h04);
    rd(A_RCP, 32'h02, "R5 recipient set then clear");
    rd(A_RCP_SET, 32'h02, "R1 set address reads register");
    wr(A_MSK_SET, 32'h03);
    rd(A_MSK, 32'h03, "R5 mask set");

    // R12 data words
    wr(A_WORD0, 32'hA5A5_0001);
    wr(4'(int'(A_WORD0) + 3), 32'h0BAD_F00D);
    wr(4'(int'(A_WORD0) + NW), 32'hFFFF_FFFF);
    rd(A_WORD0, 32'hA5A5_0001, "R12 word0");
    rd(4'(int'(A_WORD0) + 3), 32'h0BAD_F00D, "R12 last word");
    rd(4'(int'(A_WORD0) + NW), 0, "R12 beyond bank reads zero");

    // R7 R8 message interrupt
    wr(A_SEND, 32'h1);
    chk(32'(irq_raw_o), 32'h02, "R7 message raw to recipient");
    chk(32'(irq_masked_o), 32'h02, "R8 masked passes enabled bit");
    wr(A_MSK_CLR, 32'h02);
    chk(32'(irq_masked_o), 32'h00, "R8 masked blocks disabled bit");
    chk(32'(irq_raw_o), 32'h02, "R8 raw unaffected by mask");

    // R6 send encoding
    wr(A_SEND, 32'h3);
    rd(A_SEND, 32'h1, "R6 illegal 11 discarded");
    wr(A_SEND, 32'h2);
    rd(A_SEND, 32'h2, "R6 single write to acknowledge");
    chk(32'(irq_raw_o), 32'h01, "R7 acknowledge raw to owner");
    chk(32'(irq_masked_o), 32'h01, "R8 owner bit enabled in mask");
    wr(A_SEND, 32'h0);
    chk(32'(irq_raw_o), 0, "R7 clearing send drops irq");

    // R9 auto-acknowledge with two recipients
    wr(A_MODE, 32'h1);
    wr(A_RCP_SET, 32'h0A);
    wr(A_SEND, 32'h1);
    chk(32'(irq_raw_o), 32'h0A, "R7 two recipients raised");
    wr(A_RCP_CLR, 32'h02);
    rd(A_SEND, 32'h1, "R9 no ack while recipients remain");
    wr(A_RCP_CLR, 32'h08);
    chk(32'(irq_raw_o), 0, "R9 drained, ack not yet");
    @(negedge clk);
    chk(32'(irq_raw_o), 32'h01, "R9 owner acked one clock later");
    rd(A_SEND, 32'h2, "R9 send moved to acknowledge");
    rd(A_WORD0, 32'hA5A5_0001, "R9 data kept by auto-ack");

    // R10 linking
    wr(A_SEND, 32'h0);
    wr(A_MODE, 32'h3);
    wr(A_RCP_SET, 32'h02);
    wr(A_SEND, 32'h1);
    chk(32'(ack_evt_o), 0, "R10 no event before ack");
    wr(A_RCP_CLR, 32'h02);
    @(negedge clk);
    chk(32'(ack_evt_o), 1, "R10 event on ack");
    chk(32'(irq_raw_o), 0, "R10 owner irq suppressed when linked");
    @(negedge clk);
    chk(32'(ack_evt_o), 0, "R10 event lasts one cycle");

    // R11 link send while owned
    wr(A_MODE, 32'h0);
    @(negedge clk); link_send_i = 1'b1;
    @(negedge clk); link_send_i = 1'b0;
    rd(A_SEND, 32'h1, "R11 link send starts message");

    // R3 release
    wr(A_MSK_SET, 32'h04);
    wr(A_OWNER, 32'h0);
    rd(A_OWNER, 0, "R3 owner cleared");
    rd(A_RCP, 0, "R3 recipient cleared");
    rd(A_MSK, 0, "R3 mask cleared");
    rd(A_SEND, 0, "R3 send cleared");
    rd(A_MODE, 0, "R3 mode cleared");
    rd(A_WORD0, 0, "R3 data cleared");
    rd(4'(int'(A_WORD0) + 3), 0, "R3 last word cleared");

    // R11 ignored when free
    @(negedge clk); link_send_i = 1'b1;
    @(negedge clk); link_send_i = 1'b0;
    rd(A_SEND, 0, "R11 link send ignored while free");
    chk(32'(irq_raw_o), 0, "R11 no irq while free");

    // R2 reclaim by another channel
    wr(A_OWNER, 32'h80);
    rd(A_OWNER, 32'h80, "R2 reclaim after release");

    repeat (3) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule